// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Slave

This block is the command front end of a 64-position digital potentiometer. It listens on a two-wire serial bus and recovers start and stop conditions from synchronized clock and data lines. It accepts only frames sent to its own strapped address. It decodes a register-oriented instruction byte and turns each transaction into one-cycle requests to a neighbouring bank. That bank holds the volatile wiper register and four nonvolatile data registers. The block answers on the bus through a single open-drain pull-down enable.

The instruction set covers reading and writing the wiper and any data register, and copying in either direction between the wiper and a data register. It also has an open-ended stepping mode. In that mode every completed clock-high period moves the wiper one tap: up if the data line is high, down if it is low. Stores into nonvolatile registers are committed only at the stop condition. While a store is in progress the block refuses to acknowledge its address, so a master can poll for completion. An active-low protect pin suppresses those stores.

Top module: `dpot_cmd_slave`

## Requirements
- R1: The first byte after a start must equal 0,1,0,1,A3,A2,0,A0 (MSB first), with strap_i = {A3,A2,A0}. On a match the block pulls the line low in the ninth clock. Otherwise it gives no acknowledge and ignores the bus until the next start.
- R2: The instruction byte carries the opcode in bits 7:4 and the register select in bits 3:2. The opcodes are 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 data register to wiper, 1110 wiper to data register, and 0010 step mode. Any other opcode gets no acknowledge and returns the block to idle.
- R3: A write-wiper data byte is acknowledged. At the end of that acknowledge clock the block issues one write-wiper request carrying the low six bits of the byte.
- R4: For a read, the block drives the byte {2'b00, rd_data_i} MSB first, starting after the instruction acknowledge. rd_wcr_o is 1 for a wiper read, and req_sel_o selects the data register. The block changes sda_pull_o only while SCL is low.
- R5: A data-register-to-wiper copy is requested at the end of the instruction acknowledge clock, without waiting for stop.
- R6: A data register write or a wiper-to-data-register copy issues its request at the stop condition. busy_o then rises in the next cycle and stays high for NV_CYCLES cycles.
- R7: While busy_o is high, a matching address receives no acknowledge.
- R8: If wp_ni is low at the stop, a pending nonvolatile store issues no request and does not set busy_o. Its bytes are still acknowledged.
- R9: In step mode, each SCL high period that ends with a falling SCL issues one step request: up if SDA was high at the rising edge, down if it was low. The high period of the stop condition issues no step.
- R10: A start in any state abandons the current transaction, including any store still waiting for stop, and begins address reception again.
- R11: After reset, sda_pull_o, busy_o and req_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Address straps {A3,A2,A0} |
| wp_ni | input | 1 | Store protect, active low |
| sda_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| busy_o | output | 1 | Nonvolatile store in progress |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_op_o | output | 3 | Request kind: 1 wr wiper, 2 wr data reg, 3 data reg to wiper, 4 wiper to data reg, 5 step up, 6 step down |
| req_sel_o | output | 2 | Data register select |
| req_data_o | output | 6 | Write data |
| rd_wcr_o | output | 1 | Read source: 1 = wiper, 0 = data register |
| rd_data_i | input | 6 | Read value returned by the bank |

## Verification
Bus edges reach the state machine after two synchronizer stages plus one edge-compare register. An acknowledge or read bit therefore appears on sda_pull_o about three clocks after SCL falls. The bench holds every SCL phase for four clocks and samples the line at the middle of the high phase. A request reaches the bench's register bank one clock after it is issued, so bank effects are checked only through a later read transaction. busy_o rises two to four clocks after the stop's SDA edge. The bench samples it and sends the poll immediately after the stop, then waits for busy_o to drop before any further check.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam logic [3:0] DEV_ID = 4'b0101;

  localparam logic [3:0] OPC_RD_WCR = 4'b1001;
  localparam logic [3:0] OPC_WR_WCR = 4'b1010;
  localparam logic [3:0] OPC_RD_DR  = 4'b1011;
  localparam logic [3:0] OPC_WR_DR  = 4'b1100;
  localparam logic [3:0] OPC_D2W    = 4'b1101;
  localparam logic [3:0] OPC_W2D    = 4'b1110;
  localparam logic [3:0] OPC_STEP   = 4'b0010;

  localparam logic [2:0] REQ_NONE    = 3'd0;
  localparam logic [2:0] REQ_WR_WCR  = 3'd1;
  localparam logic [2:0] REQ_WR_DR   = 3'd2;
  localparam logic [2:0] REQ_D2W     = 3'd3;
  localparam logic [2:0] REQ_W2D     = 3'd4;
  localparam logic [2:0] REQ_STEP_UP = 3'd5;
  localparam logic [2:0] REQ_STEP_DN = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_INSTR, S_INSTR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_STEP, S_WAIT
  } fsm_e;
endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] scl_sh, sda_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LEN-2:0], scl_i};
      sda_sh <= {sda_sh[LEN-2:0], sda_i};
    end
  end

  logic scl_p, sda_p;
  assign scl_o = scl_sh[STAGES-1];
  assign sda_o = sda_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_p = sda_sh[STAGES];

  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA moving while SCL stays high
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
  parameter int NV_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(NV_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r6_busy_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r6_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/dpot_cmd_slave.sv
module dpot_cmd_slave
  import dpot_pkg::*;
#(
  parameter int DATA_W    = 6,
  parameter int SEL_W     = 2,
  parameter int SYNC_LEN  = 2,
  parameter int NV_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              wp_ni,
  output logic              sda_pull_o,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic [2:0]        req_op_o,
  output logic [SEL_W-1:0]  req_sel_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              rd_wcr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int BYTE_W = 8;
  localparam int PAD_W  = BYTE_W - DATA_W;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic scl_s, scl_rise, scl_fall, sda_s, start_c, stop_c;

  dpot_bus_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .sda_o(sda_s), .start_o(start_c), .stop_o(stop_c)
  );

  fsm_e              state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [3:0]        opc_q;
  logic [SEL_W-1:0]  sel_q;
  logic              pull_q, dir_q, nv_pend_q;
  logic [2:0]        nv_op_q;
  logic              req_valid_q;
  logic [2:0]        req_op_q;
  logic [DATA_W-1:0] data_q;

  logic addr_ok, opc_ok, nv_req;
  assign addr_ok = (sh_q[7:4] == DEV_ID) && (sh_q[3] == strap_i[2]) &&
                   (sh_q[2] == strap_i[1]) && !sh_q[1] && (sh_q[0] == strap_i[0]);
  always_comb begin
    unique case (sh_q[7:4])
      OPC_RD_WCR, OPC_WR_WCR, OPC_RD_DR, OPC_WR_DR,
      OPC_D2W, OPC_W2D, OPC_STEP: opc_ok = 1'b1;
      default:                    opc_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      opc_q       <= '0;
      sel_q       <= '0;
      pull_q      <= 1'b0;
      dir_q       <= 1'b0;
      nv_pend_q   <= 1'b0;
      nv_op_q     <= REQ_NONE;
      req_valid_q <= 1'b0;
      req_op_q    <= REQ_NONE;
      data_q      <= '0;
    end else begin
      req_valid_q <= 1'b0;
      if (start_c) begin
        state_q   <= S_ADDR;
        bit_cnt_q <= '0;
        pull_q    <= 1'b0;
        nv_pend_q <= 1'b0;
      end else if (stop_c) begin
        state_q   <= S_IDLE;
        pull_q    <= 1'b0;
        nv_pend_q <= 1'b0;
        if (nv_pend_q && wp_ni) begin
          req_valid_q <= 1'b1;
          req_op_q    <= nv_op_q;
        end
      end else begin
        unique case (state_q)
          S_ADDR, S_INSTR, S_WDATA: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) begin
              sh_q      <= {sh_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
              bit_cnt_q <= '0;
              if (state_q == S_ADDR) begin
                if (addr_ok && !busy_o) begin
                  pull_q  <= 1'b1;
                  state_q <= S_ADDR_ACK;
                end else state_q <= S_IDLE;
              end else if (state_q == S_INSTR) begin
                if (opc_ok) begin
                  pull_q  <= 1'b1;
                  opc_q   <= sh_q[7:4];
                  sel_q   <= sh_q[3:2];
                  state_q <= S_INSTR_ACK;
                end else state_q <= S_IDLE;
              end else begin
                pull_q  <= 1'b1;
                data_q  <= sh_q[DATA_W-1:0];
                state_q <= S_WDATA_ACK;
              end
            end
          end
          S_ADDR_ACK: if (scl_fall) begin
            pull_q  <= 1'b0;
            state_q <= S_INSTR;
          end
          S_INSTR_ACK: if (scl_fall) begin
            pull_q  <= 1'b0;
            state_q <= S_WAIT;
            unique case (opc_q)
              OPC_RD_WCR, OPC_RD_DR: begin
                sh_q    <= {{PAD_W{1'b0}}, rd_data_i};
                pull_q  <= 1'b1;   // MSB of pad is 0
                state_q <= S_RDATA;
              end
              OPC_WR_WCR, OPC_WR_DR: state_q <= S_WDATA;
              OPC_D2W: begin
                req_valid_q <= 1'b1;
                req_op_q    <= REQ_D2W;
              end
              OPC_W2D: begin
                nv_pend_q <= 1'b1;
                nv_op_q   <= REQ_W2D;
              end
              default: state_q <= S_STEP;
            endcase
          end
          S_WDATA_ACK: if (scl_fall) begin
            pull_q  <= 1'b0;
            state_q <= S_WAIT;
            if (opc_q == OPC_WR_WCR) begin
              req_valid_q <= 1'b1;
              req_op_q    <= REQ_WR_WCR;
            end else begin
              nv_pend_q <= 1'b1;
              nv_op_q   <= REQ_WR_DR;
            end
          end
          S_RDATA: if (scl_fall) begin
            sh_q      <= {sh_q[BYTE_W-2:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT - 1'b1) begin
              pull_q  <= 1'b0;   // master acknowledge slot
              state_q <= S_WAIT;
            end else pull_q <= ~sh_q[BYTE_W-2];
          end
          S_STEP: begin
            if (scl_rise) dir_q <= sda_s;
            else if (scl_fall) begin
              req_valid_q <= 1'b1;
              req_op_q    <= dir_q ? REQ_STEP_UP : REQ_STEP_DN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  dpot_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i(req_valid_q && (req_op_q == REQ_WR_DR || req_op_q == REQ_W2D)),
    .busy_o
  );

  assign sda_pull_o  = pull_q;
  assign req_valid_o = req_valid_q;
  assign req_op_o    = req_op_q;
  assign req_sel_o   = sel_q;
  assign req_data_o  = data_q;
  assign rd_wcr_o    = (opc_q == OPC_RD_WCR);

  a_r4_pull_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_s);
  a_r6_busy_after_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_o && (req_op_o == REQ_WR_DR || req_op_o == REQ_W2D)));
  a_r7_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_pull_o) && state_q == S_ADDR_ACK) |-> !busy_o);
  a_r8_wp_blocks_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && (req_op_o == REQ_WR_DR || req_op_o == REQ_W2D)) |-> $past(wp_ni));
  a_r9_step_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && (req_op_o == REQ_STEP_UP || req_op_o == REQ_STEP_DN)) |-> $past(state_q == S_STEP));
endmodule

// File: tb/dpot_cmd_slave_tb_top.sv
module dpot_cmd_slave_tb_top;
  localparam int NV = 400;
  localparam int Q  = 4;
  localparam logic [7:0] ADDR = 8'h59;   // straps {A3,A2,A0} = 3'b101

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, wp_n = 1'b1;
  logic pull, busy, req_valid, rd_wcr;
  logic [2:0] req_op;
  logic [1:0] req_sel;
  logic [5:0] req_data, rd_data;
  logic sda_line;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~pull;

  dpot_cmd_slave #(.NV_CYCLES(NV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(3'b101),
    .wp_ni(wp_n), .sda_pull_o(pull), .busy_o(busy), .req_valid_o(req_valid),
    .req_op_o(req_op), .req_sel_o(req_sel), .req_data_o(req_data),
    .rd_wcr_o(rd_wcr), .rd_data_i(rd_data)
  );

  // register bank driven by the requests
  logic [5:0] wcr;
  logic [5:0] dr [4];
  assign rd_data = rd_wcr ? wcr : dr[req_sel];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcr <= '0;
      for (int i = 0; i < 4; i++) dr[i] <= '0;
    end else if (req_valid) begin
      case (req_op)
        3'd1: wcr <= req_data;
        3'd2: dr[req_sel] <= req_data;
        3'd3: wcr <= dr[req_sel];
        3'd4: dr[req_sel] <= wcr;
        3'd5: if (wcr != 6'd63) wcr <= wcr + 1'b1;
        3'd6: if (wcr != 6'd0) wcr <= wcr - 1'b1;
        default: ;
      endcase
    end
  end

  function automatic logic [5:0] f_step(input logic [5:0] w, input bit up);
    if (up) return (w == 6'd63) ? w : w + 1'b1;
    return (w == 6'd0) ? w : w - 1'b1;
  endfunction
  function automatic logic [7:0] f_instr(input logic [3:0] opc, input logic [1:0] sel);
    return {opc, sel, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); m_sda = 1; wq(); scl = 1; wq(); m_sda = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_stop(); m_sda = 0; wq(); scl = 1; wq(); m_sda = 1; wq(); endtask
  task automatic bit_x(input bit b, output bit s);
    m_sda = b; wq(); scl = 1; wq(); s = sda_line; wq(); scl = 0; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = !s;
  endtask
  task automatic recv_byte(output logic [7:0] d);
    bit s;
    d = '0;
    for (int i = 0; i < 8; i++) begin bit_x(1'b1, s); d = {d[6:0], s}; end
    bit_x(1'b0, s);
  endtask

  // full transaction; acks a0..a2, read byte rb
  task automatic txn(input logic [3:0] opc, input logic [1:0] sel, input bit wr, input logic [7:0] wb,
                     input bit rd, output bit a0, output bit a1, output bit a2, output logic [7:0] rb);
    a1 = 0; a2 = 0; rb = 8'hxx;
    bus_start();
    send_byte(ADDR, a0);
    if (a0) begin
      send_byte(f_instr(opc, sel), a1);
      if (a1 && wr) send_byte(wb, a2);
      if (a1 && rd) recv_byte(rb);
    end
    bus_stop();
    wq();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    wq();
  endtask

  task automatic rd_wcr_chk(input logic [5:0] exp, input string req);
    bit a0, a1, a2; logic [7:0] rb;
    txn(4'b1001, 2'd0, 0, 8'h00, 1, a0, a1, a2, rb);
    chk(a0 && a1 && rb == {2'b00, exp}, req, int'(rb), int'({2'b00, exp}));
  endtask
  task automatic rd_dr_chk(input logic [1:0] sel, input logic [5:0] exp, input string req);
    bit a0, a1, a2; logic [7:0] rb;
    txn(4'b1011, sel, 0, 8'h00, 1, a0, a1, a2, rb);
    chk(a0 && a1 && rb == {2'b00, exp}, req, int'(rb), int'({2'b00, exp}));
  endtask

  logic [5:0] e_wcr;
  logic [5:0] e_dr [4];

  initial begin
    bit a0, a1, a2, s;
    logic [7:0] rb;
    void'($urandom(32'h1d5e));
    e_wcr = 0;
    for (int i = 0; i < 4; i++) e_dr[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!pull && !busy && !req_valid, "R11 reset outputs", {pull, busy, req_valid}, 0);
    rst_n = 1'b1;
    wq();

    // R1 address mismatch: A3 wrong, then fixed zero bit set
    bus_start(); send_byte(8'h51, a0); bus_stop(); wq();
    chk(!a0, "R1 A3 mismatch nack", a0, 0);
    bus_start(); send_byte(8'h5B, a0); send_byte(f_instr(4'b1010, 0), a1); send_byte(8'h2A, a2); bus_stop(); wq();
    chk(!a0 && !a1 && !a2, "R1 fixed bit mismatch ignored", {a0, a1, a2}, 0);
    rd_wcr_chk(e_wcr, "R1 wiper untouched after foreign frame");

    // R3/R4 random wiper writes and reads
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      txn(4'b1010, 2'($urandom), 1, v, 0, a0, a1, a2, rb);
      chk(a0 && a1 && a2, "R3 write wiper acks", {a0, a1, a2}, 7);
      e_wcr = v[5:0];
      rd_wcr_chk(e_wcr, "R4 read wiper");
    end

    // R2 undefined opcode
    txn(4'b0011, 2'd1, 0, 8'h00, 0, a0, a1, a2, rb);
    chk(a0 && !a1, "R2 undefined opcode nack", a1, 0);
    txn(4'b1111, 2'd0, 0, 8'h00, 0, a0, a1, a2, rb);
    chk(!a1, "R2 opcode 1111 nack", a1, 0);

    // R6/R7 data register writes with polling
    for (int k = 0; k < 4; k++) begin
      logic [5:0] v;
      v = 6'($urandom);
      txn(4'b1100, 2'(k), 1, {2'b00, v}, 0, a0, a1, a2, rb);
      chk(a0 && a1 && a2, "R6 write data reg acks", {a0, a1, a2}, 7);
      chk(busy, "R6 busy after stop", busy, 1);
      bus_start(); send_byte(ADDR, a0); bus_stop(); wq();
      chk(!a0, "R7 address nack while busy", a0, 0);
      wait_idle();
      bus_start(); send_byte(ADDR, a0); bus_stop(); wq();
      chk(a0, "R7 address ack after store", a0, 1);
      e_dr[k] = v;
    end
    for (int k = 0; k < 4; k++) rd_dr_chk(2'(k), e_dr[k], "R4 read data reg");

    // R6 busy length: high for NV cycles then low
    txn(4'b1100, 2'd2, 1, 8'h15, 0, a0, a1, a2, rb);
    e_dr[2] = 6'h15;
    repeat (NV - 40) @(negedge clk);
    chk(busy, "R6 busy still high", busy, 1);
    repeat (60) @(negedge clk);
    chk(!busy, "R6 busy cleared", busy, 0);

    // R5 data reg to wiper
    txn(4'b1101, 2'd2, 0, 8'h00, 0, a0, a1, a2, rb);
    chk(a0 && a1 && !busy, "R5 copy acked, no busy", {a0, a1, busy}, 6);
    e_wcr = e_dr[2];
    rd_wcr_chk(e_wcr, "R5 wiper loaded from data reg");

    // R6 wiper to data reg
    txn(4'b1010, 0, 1, 8'h3C, 0, a0, a1, a2, rb);
    e_wcr = 6'h3C;
    txn(4'b1110, 2'd1, 0, 8'h00, 0, a0, a1, a2, rb);
    chk(busy, "R6 copy to data reg sets busy", busy, 1);
    wait_idle();
    e_dr[1] = e_wcr;
    rd_dr_chk(2'd1, e_dr[1], "R6 data reg holds wiper");

    // R8 write protect
    wp_n = 1'b0;
    txn(4'b1100, 2'd3, 1, 8'h07, 0, a0, a1, a2, rb);
    chk(a0 && a1 && a2, "R8 protected write still acked", {a0, a1, a2}, 7);
    chk(!busy, "R8 no busy when protected", busy, 1'b0);
    txn(4'b1110, 2'd0, 0, 8'h00, 0, a0, a1, a2, rb);
    chk(!busy, "R8 no busy on protected copy", busy, 1'b0);
    wp_n = 1'b1;
    rd_dr_chk(2'd3, e_dr[3], "R8 data reg 3 unchanged");
    rd_dr_chk(2'd0, e_dr[0], "R8 data reg 0 unchanged");

    // R9 step mode, random directions, including clamping runs
    for (int r = 0; r < 3; r++) begin
      int n;
      n = (r == 0) ? 70 : int'($urandom_range(30, 5));
      bus_start(); send_byte(ADDR, a0); send_byte(f_instr(4'b0010, 0), a1);
      chk(a0 && a1, "R9 step mode acked", {a0, a1}, 3);
      for (int i = 0; i < n; i++) begin
        bit up;
        up = (r == 0) ? 1'b1 : 1'($urandom);
        bit_x(up, s);
        e_wcr = f_step(e_wcr, up);
      end
      bus_stop(); wq();
      rd_wcr_chk(e_wcr, "R9 wiper after steps");
    end
    bus_start(); send_byte(ADDR, a0); send_byte(f_instr(4'b0010, 0), a1);
    for (int i = 0; i < 3; i++) begin bit_x(1'b0, s); e_wcr = f_step(e_wcr, 0); end
    bus_stop(); wq();
    rd_wcr_chk(e_wcr, "R9 stop period not a step");

    // R10 repeated start drops pending store
    bus_start(); send_byte(ADDR, a0); send_byte(f_instr(4'b1100, 2'd0), a1); send_byte(8'h2B, a2);
    bus_start(); send_byte(ADDR, a0); send_byte(f_instr(4'b1011, 2'd0), a1); recv_byte(rb);
    bus_stop(); wq();
    chk(a0 && a1 && rb == {2'b00, e_dr[0]}, "R10 restart discards store", int'(rb), int'({2'b00, e_dr[0]}));
    chk(!busy, "R10 no busy after restart", busy, 0);
    // restart in the middle of the address byte
    bus_start(); bit_x(0, s); bit_x(1, s); bit_x(0, s);
    bus_start(); send_byte(ADDR, a0); bus_stop(); wq();
    chk(a0, "R10 restart mid-address acked", a0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule